// File: doc/BRIEF.md
# Width-converting stream FIFO

This block is a single-clock valid/ready FIFO whose write side and read side may have different data widths, provided the wider one is a power-of-two multiple of the narrower one. Storage is split into identical lanes, each one narrow word wide. When the write side is narrow, successive input beats fill the lanes in turn and a full row leaves as one wide beat. When the write side is wide, each input beat is cut across all lanes and the read side walks the lanes one narrow beat at a time. Each beat carries data, a per-byte keep mask and an end-of-packet flag.

With keep handling enabled, an input beat whose keep mask is all zero and whose end flag is low is accepted and then thrown away. A beat whose keep mask is all zero but whose end flag is high is stored and delivered, so that the packet boundary is not lost. Two counters report free space (`room`, in input words) and stored data (`level`, in output words). Both change on the handshakes themselves, so they stay exact when dropped beats and packet ends leave lanes unevenly filled.

Back-pressure rules: a transfer happens on any clock edge where valid and ready are both high. `in_ready` depends only on `room`. `out_valid` depends only on `level` and never on `out_ready`. Once `out_valid` is raised, it and the output beat hold still until the beat is taken.

Top module: `width_conv_fifo`

## Requirements
- R1: Narrow-to-wide packing. The first input beat of a row goes in the least-significant output lane (byte lane 0 of `out_data`). `out_keep` is the concatenation of the lane keeps, with lane i at bits [i*NB +: NB].
- R2: When an input beat with `in_last`=1 lands partway through a wide row, that row is emitted at once with `out_last`=1. The unused upper lanes have keep 0 and data 0.
- R3: Wide-to-narrow split. An input beat leaves as LANES output beats, lowest slice first. Each carries its own slice of the keep mask, and only the final slice carries `out_last`.
- R4: With keep handling enabled, an accepted beat with `in_keep`=0 and `in_last`=0 produces no output and changes neither `room` nor `level`.
- R5: An accepted beat with `in_keep`=0 and `in_last`=1 is stored and delivered with keep 0 and `out_last`=1.
- R6: `out_valid` is high whenever data is stored, whatever `out_ready` is. While `out_ready` is low, `out_valid`, `out_data`, `out_keep` and `out_last` hold their values.
- R7: `room` counts free input words. It starts at capacity (LANES*DEPTH when packing, DEPTH when splitting). It drops by one per stored beat, and in packing mode also by the padded lanes of a row ended early. It rises as storage is freed by reads.
- R8: `level` counts output words ready to read. It rises by one per completed row when packing and by LANES per stored beat when splitting. It falls by one per output handshake.
- R9: A write and a read in the same cycle update `room` and `level` by the net of both effects.
- R10: `in_ready` is low exactly when `room` is 0. `out_valid` is low exactly when `level` is 0.
- R11: The synchronous active-low `rst_n` empties the FIFO: `room` returns to capacity, `level` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | FIFO can accept a beat |
| in_data | input | IN_BYTES*8 | Input data |
| in_keep | input | IN_BYTES | Input per-byte keep mask |
| in_last | input | 1 | Input end of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | OUT_BYTES*8 | Output data |
| out_keep | output | OUT_BYTES | Output per-byte keep mask |
| out_last | output | 1 | Output end of packet |
| room | output | clog2(LANES*DEPTH+1) | Free space in input words |
| level | output | clog2(LANES*DEPTH+1) | Stored data in output words |

## Verification
The bench fills a 1-to-4-byte instance with a packet that ends on lane 0, a null non-final beat, a null final beat and a packet ending on lane 1, so that the counters and the padding are both exercised. A design that sums lane fill levels would report the wrong `room` after a padded row. A design that drops the null final beat would lose the packet boundary. The bench also holds `out_ready` low with data stored: a design that gates valid on ready would show no beat there. Further checks cover a write and a read in the same cycle, where a counter that applies only one of the two effects goes wrong; a null beat into an empty FIFO, which must leave `out_valid` low; and a 4-to-1-byte instance whose end flag must land on the fourth slice only.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  function automatic int lane_count(int ib, int ob);
    return (ib > ob) ? ib / ob : ob / ib;
  endfunction

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int ctr_width(int ib, int ob, int depth);
    return $clog2(lane_count(ib, ob) * depth + 1);
  endfunction
endpackage

// File: rtl/wcf_lane.sv
module wcf_lane #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wr_ent,
  input  logic         pop,
  output logic [W-1:0] rd_ent
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wr_ent;
        wp      <= bump(wp);
      end
      if (pop) rp <= bump(rp);
    end
  end

  assign rd_ent = mem[rp];
endmodule

// File: rtl/wcf_occ_ctr.sv
module wcf_occ_ctr #(
  parameter int CW   = 5,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] add,
  input  logic [CW-1:0] sub,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= CW'(INIT);
    else        cnt <= cnt + add - sub;
  end
endmodule

// File: rtl/width_conv_fifo.sv
module width_conv_fifo
  import wcf_pkg::*;
#(
  parameter int IN_BYTES  = 1,
  parameter int OUT_BYTES = 4,
  parameter int DEPTH     = 4,
  parameter bit KEEP_EN   = 1'b1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  output logic                                          in_ready,
  input  logic [IN_BYTES*8-1:0]                         in_data,
  input  logic [IN_BYTES-1:0]                           in_keep,
  input  logic                                          in_last,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [OUT_BYTES*8-1:0]                        out_data,
  output logic [OUT_BYTES-1:0]                          out_keep,
  output logic                                          out_last,
  output logic [ctr_width(IN_BYTES,OUT_BYTES,DEPTH)-1:0] room,
  output logic [ctr_width(IN_BYTES,OUT_BYTES,DEPTH)-1:0] level
);
  localparam bit UPSIZE   = (IN_BYTES <= OUT_BYTES);
  localparam int NB       = UPSIZE ? IN_BYTES : OUT_BYTES;
  localparam int LANES    = lane_count(IN_BYTES, OUT_BYTES);
  localparam int LW       = NB * 8;
  localparam int EW       = LW + NB + 1;
  localparam int SW       = idx_width(LANES);
  localparam int CW       = ctr_width(IN_BYTES, OUT_BYTES, DEPTH);
  localparam int ROOM_MAX = UPSIZE ? LANES * DEPTH : DEPTH;

  logic [EW-1:0]    wr_ent [LANES];
  logic [EW-1:0]    rd_ent [LANES];
  logic [LANES-1:0] push, pop;
  logic [CW-1:0]    room_add, room_sub, level_add, level_sub;
  logic             in_fire, out_fire, null_beat, store;

  assign in_ready  = (room != '0);
  assign out_valid = (level != '0);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign null_beat = KEEP_EN && (in_keep == '0) && !in_last;
  assign store     = in_fire && !null_beat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wcf_lane #(.W(EW), .DEPTH(DEPTH)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push[i]),
      .wr_ent (wr_ent[i]),
      .pop    (pop[i]),
      .rd_ent (rd_ent[i])
    );
  end

  if (UPSIZE) begin : g_pack
    logic [SW-1:0]    wsel;
    logic             row_done;
    logic [LANES-1:0] lastv;

    for (genvar i = 0; i < LANES; i++) begin : g_col
      assign push[i]   = store && ((SW'(i) == wsel) || (in_last && (SW'(i) > wsel)));
      assign wr_ent[i] = (SW'(i) == wsel) ? {in_last, in_keep, in_data} : '0;
      assign pop[i]    = out_fire;
      assign out_data[i*LW +: LW] = rd_ent[i][LW-1:0];
      assign out_keep[i*NB +: NB] = rd_ent[i][LW +: NB];
      assign lastv[i]             = rd_ent[i][EW-1];
    end

    assign out_last = |lastv;
    assign row_done = store && ((wsel == SW'(LANES - 1)) || in_last);

    always_ff @(posedge clk) begin
      if (!rst_n)     wsel <= '0;
      else if (store) wsel <= row_done ? '0 : wsel + 1'b1;
    end

    assign room_add  = out_fire ? CW'(LANES) : '0;
    assign room_sub  = store ? (in_last ? CW'(LANES) - CW'(wsel) : CW'(1)) : '0;
    assign level_add = CW'(row_done);
    assign level_sub = CW'(out_fire);
  end else begin : g_split
    logic [SW-1:0] rsel;
    logic          row_end;

    for (genvar i = 0; i < LANES; i++) begin : g_col
      assign push[i]   = store;
      assign wr_ent[i] = {in_last && (i == LANES - 1), in_keep[i*NB +: NB], in_data[i*LW +: LW]};
      assign pop[i]    = out_fire && (rsel == SW'(i));
    end

    assign out_data = rd_ent[rsel][LW-1:0];
    assign out_keep = rd_ent[rsel][LW +: NB];
    assign out_last = rd_ent[rsel][EW-1];
    assign row_end  = (rsel == SW'(LANES - 1));

    always_ff @(posedge clk) begin
      if (!rst_n)        rsel <= '0;
      else if (out_fire) rsel <= row_end ? '0 : rsel + 1'b1;
    end

    assign room_add  = CW'(out_fire && row_end);
    assign room_sub  = CW'(store);
    assign level_add = store ? CW'(LANES) : '0;
    assign level_sub = CW'(out_fire);
  end

  wcf_occ_ctr #(.CW(CW), .INIT(ROOM_MAX)) u_room (
    .clk (clk), .rst_n (rst_n), .add (room_add), .sub (room_sub), .cnt (room)
  );

  wcf_occ_ctr #(.CW(CW), .INIT(0)) u_level (
    .clk (clk), .rst_n (rst_n), .add (level_add), .sub (level_sub), .cnt (level)
  );
endmodule

// File: rtl/wcf_checker.sv
module wcf_checker
  import wcf_pkg::*;
#(
  parameter int IN_BYTES  = 1,
  parameter int OUT_BYTES = 4,
  parameter int DEPTH     = 4,
  parameter bit KEEP_EN   = 1'b1
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          in_valid,
  input logic                                          in_ready,
  input logic [IN_BYTES-1:0]                           in_keep,
  input logic                                          in_last,
  input logic                                          out_valid,
  input logic                                          out_ready,
  input logic [OUT_BYTES*8-1:0]                        out_data,
  input logic [OUT_BYTES-1:0]                          out_keep,
  input logic                                          out_last,
  input logic [ctr_width(IN_BYTES,OUT_BYTES,DEPTH)-1:0] room,
  input logic [ctr_width(IN_BYTES,OUT_BYTES,DEPTH)-1:0] level
);
  localparam bit UPSIZE    = (IN_BYTES <= OUT_BYTES);
  localparam int LANES     = lane_count(IN_BYTES, OUT_BYTES);
  localparam int ROOM_MAX  = UPSIZE ? LANES * DEPTH : DEPTH;
  localparam int LEVEL_MAX = UPSIZE ? DEPTH : LANES * DEPTH;

  assert_room_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    room <= ROOM_MAX);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LEVEL_MAX);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep)
                                && $stable(out_last));

  assert_drop_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && KEEP_EN && (in_keep == '0) && !in_last
    && !(out_valid && out_ready) |=> $stable(room) && $stable(level));

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (room == '0) |-> !in_ready);

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |=> (room == ROOM_MAX) && (level == '0) && !out_valid);
endmodule

bind width_conv_fifo wcf_checker #(
  .IN_BYTES (IN_BYTES), .OUT_BYTES (OUT_BYTES), .DEPTH (DEPTH), .KEEP_EN (KEEP_EN)
) u_chk (
  .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
  .in_keep (in_keep), .in_last (in_last), .out_valid (out_valid),
  .out_ready (out_ready), .out_data (out_data), .out_keep (out_keep),
  .out_last (out_last), .room (room), .level (level)
);

// File: tb/width_conv_fifo_test.sv
`timescale 1ns/1ps
module width_conv_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // packing instance: 1 byte in, 4 bytes out, 4 rows
  logic        u_in_valid = 0, u_in_ready, u_in_last = 0;
  logic [7:0]  u_in_data = '0;
  logic [0:0]  u_in_keep = '0;
  logic        u_out_valid, u_out_ready = 0, u_out_last;
  logic [31:0] u_out_data;
  logic [3:0]  u_out_keep;
  logic [4:0]  u_room, u_level;

  // splitting instance: 4 bytes in, 1 byte out, 4 rows
  logic        d_in_valid = 0, d_in_ready, d_in_last = 0;
  logic [31:0] d_in_data = '0;
  logic [3:0]  d_in_keep = '0;
  logic        d_out_valid, d_out_ready = 0, d_out_last;
  logic [7:0]  d_out_data;
  logic [0:0]  d_out_keep;
  logic [4:0]  d_room, d_level;

  width_conv_fifo #(.IN_BYTES(1), .OUT_BYTES(4), .DEPTH(4), .KEEP_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(u_in_valid), .in_ready(u_in_ready),
    .in_data(u_in_data), .in_keep(u_in_keep), .in_last(u_in_last),
    .out_valid(u_out_valid), .out_ready(u_out_ready), .out_data(u_out_data),
    .out_keep(u_out_keep), .out_last(u_out_last), .room(u_room), .level(u_level));

  width_conv_fifo #(.IN_BYTES(4), .OUT_BYTES(1), .DEPTH(4), .KEEP_EN(1'b1)) uut_dn (
    .clk(clk), .rst_n(rst_n), .in_valid(d_in_valid), .in_ready(d_in_ready),
    .in_data(d_in_data), .in_keep(d_in_keep), .in_last(d_in_last),
    .out_valid(d_out_valid), .out_ready(d_out_ready), .out_data(d_out_data),
    .out_keep(d_out_keep), .out_last(d_out_last), .room(d_room), .level(d_level));

  // {data, keep, last, expected room, expected level} after each beat
  localparam logic [19:0] UP_IN [9] = '{
    {8'h11, 1'b1, 1'b0, 5'd15, 5'd0},
    {8'h22, 1'b1, 1'b0, 5'd14, 5'd0},
    {8'h00, 1'b0, 1'b0, 5'd14, 5'd0},
    {8'h33, 1'b1, 1'b0, 5'd13, 5'd0},
    {8'h44, 1'b1, 1'b0, 5'd12, 5'd1},
    {8'h55, 1'b1, 1'b1, 5'd8,  5'd2},
    {8'h66, 1'b0, 1'b1, 5'd4,  5'd3},
    {8'h77, 1'b1, 1'b0, 5'd3,  5'd3},
    {8'h88, 1'b1, 1'b1, 5'd0,  5'd4}
  };
  // {data, keep, last} of each wide output beat
  localparam logic [36:0] UP_OUT [4] = '{
    {32'h44332211, 4'hF, 1'b0},
    {32'h00000055, 4'h1, 1'b1},
    {32'h00000066, 4'h0, 1'b1},
    {32'h00008877, 4'h3, 1'b1}
  };
  localparam logic [9:0] DN_OUT [8] = '{
    {8'hA1, 1'b1, 1'b0}, {8'hA2, 1'b1, 1'b0}, {8'hA3, 1'b1, 1'b0}, {8'hA4, 1'b1, 1'b0},
    {8'hB1, 1'b1, 1'b0}, {8'hB2, 1'b1, 1'b0}, {8'hB3, 1'b0, 1'b0}, {8'hB4, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic up_beat(input logic [7:0] d, input logic k, input logic l);
    @(negedge clk);
    u_in_valid = 1; u_in_data = d; u_in_keep = k; u_in_last = l;
    @(posedge clk);
    @(negedge clk);
    u_in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset room", u_room, 16);
    check("R11 reset level", u_level, 0);
    check("R10 reset in_ready", u_in_ready, 1);
    check("R10 reset out_valid", u_out_valid, 0);
    check("R11 split reset room", d_room, 4);
    rst_n = 1;

    // vector table: fill the packing instance
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      u_in_valid = 1;
      {u_in_data, u_in_keep, u_in_last} = UP_IN[i][19:10];
      @(posedge clk);
      #1;
      check($sformatf("R7 room row %0d", i), u_room, UP_IN[i][9:5]);
      check($sformatf("R8 level row %0d", i), u_level, UP_IN[i][4:0]);
    end
    @(negedge clk);
    u_in_valid = 0;
    check("R10 full in_ready", u_in_ready, 0);

    // stall: valid without ready, beat held
    for (int i = 0; i < 3; i++) begin
      check("R6 valid without ready", u_out_valid, 1);
      check("R6 held data", u_out_data, 32'h44332211);
      @(negedge clk);
    end

    u_out_ready = 1;
    for (int j = 0; j < 4; j++) begin
      check($sformatf("R6 drain valid %0d", j), u_out_valid, 1);
      check($sformatf("R1 R2 R5 data %0d", j), u_out_data, UP_OUT[j][36:5]);
      check($sformatf("R1 R2 R5 keep %0d", j), u_out_keep, UP_OUT[j][4:1]);
      check($sformatf("R2 R5 last %0d", j), u_out_last, UP_OUT[j][0]);
      @(posedge clk);
      @(negedge clk);
    end
    check("R10 empty out_valid", u_out_valid, 0);
    check("R7 drained room", u_room, 16);
    check("R8 drained level", u_level, 0);
    u_out_ready = 0;

    // simultaneous write and read
    for (int i = 1; i <= 4; i++) up_beat(8'(i), 1'b1, 1'b0);
    check("R8 one row level", u_level, 1);
    check("R7 one row room", u_room, 12);
    u_in_valid = 1; u_in_data = 8'h05; u_in_keep = 1; u_in_last = 0;
    u_out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    u_in_valid = 0; u_out_ready = 0;
    check("R9 concurrent room", u_room, 15);
    check("R9 concurrent level", u_level, 0);

    // reset mid-fill
    up_beat(8'h06, 1'b1, 1'b1);
    check("R2 early end level", u_level, 1);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R11 midfill room", u_room, 16);
    check("R11 midfill level", u_level, 0);
    check("R11 midfill out_valid", u_out_valid, 0);

    // null non-final beat into empty FIFO
    @(negedge clk);
    check("R4 null accepted", u_in_ready, 1);
    up_beat(8'hEE, 1'b0, 1'b0);
    check("R4 null out_valid", u_out_valid, 0);
    check("R4 null level", u_level, 0);
    check("R4 null room", u_room, 16);

    // splitting instance
    @(negedge clk);
    d_in_valid = 1; d_in_data = 32'hA4A3A2A1; d_in_keep = 4'hF; d_in_last = 0;
    @(posedge clk);
    @(negedge clk);
    check("R7 split room", d_room, 3);
    check("R8 split level", d_level, 4);
    d_in_data = 32'h0; d_in_keep = 4'h0;
    @(posedge clk);
    @(negedge clk);
    check("R4 split null room", d_room, 3);
    check("R4 split null level", d_level, 4);
    d_in_data = 32'hB4B3B2B1; d_in_keep = 4'h3; d_in_last = 1;
    @(posedge clk);
    @(negedge clk);
    d_in_valid = 0;
    check("R8 split level two", d_level, 8);
    d_out_ready = 1;
    for (int j = 0; j < 8; j++) begin
      if (j == 0) check("R7 split room before read", d_room, 2);
      if (j == 4) check("R7 split room row freed", d_room, 3);
      check($sformatf("R3 data %0d", j), d_out_data, DN_OUT[j][9:2]);
      check($sformatf("R3 keep %0d", j), d_out_keep, DN_OUT[j][1]);
      check($sformatf("R3 last %0d", j), d_out_last, DN_OUT[j][0]);
      @(posedge clk);
      @(negedge clk);
    end
    d_out_ready = 0;
    check("R7 split drained room", d_room, 4);
    check("R10 split empty", d_out_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule